// File: doc/BRIEF.md
# Debug Ring Shift Node

This block is one station of a serial debug chain. Many stations are strung in a loop. Each station puts a shift register between the serial bit arriving from the previous station and the serial bit leaving for the next one. A master sends a single control wire to every station in parallel. It also feeds the first station's serial input and collects the last station's serial output.

The control wire carries a two-cycle code. A low cycle with no code pending is idle. A high cycle followed by a low cycle moves the whole chain by one bit position, least significant bit first. A high cycle followed by a second high cycle performs a swap in both directions at once:
- the station captures its local debug value into the shift register;
- the word that was shifted into the station appears on a local output register.

The control wire and the serial input both pass through the same number of pipeline registers before the decoder uses them, so that they stay aligned across long routing.

Top module: `dbg_ring_node`

## Requirements
- R1: A synchronous active-high reset clears the shift register, the local output register, the serial output and the code decoder. After reset the first high control cycle is taken as the first cycle of a code.
- R2: While no code is being decoded (control low with no first code cycle pending), the shift register and the local output register keep their values, whatever the serial input does.
- R3: The code high-then-low shifts the register one place toward bit 0. The serial input value present during the second (low) code cycle enters bit WIDTH-1. The serial output always equals bit 0 of the shift register.
- R4: A WIDTH-bit word fed in through WIDTH consecutive shift codes, least significant bit first, ends up in the register unchanged. Meanwhile the previous contents leave on the serial output, least significant bit first.
- R5: The code high-then-high loads the local input word into the shift register. In the same clock, the old shift register contents go to the local output register. The local output register changes on no other code.
- R6: The effect of a code reaches the outputs exactly CTL_STAGES rising edges after the edge that samples its second cycle, and not earlier. The serial input is delayed by the same CTL_STAGES stages.
- R7: Codes may follow each other with no idle cycle between them. Each pair of control cycles is decoded on its own, and at most one action takes place in any two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all registers on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ringCtl | input | 1 | Two-cycle control code from the master |
| ringDi | input | 1 | Serial data from the previous station |
| ringDo | output | 1 | Serial data to the next station (bit 0 of the shift register) |
| localIn | input | WIDTH | Local debug value captured on a load |
| localOut | output | WIDTH | Word received over the chain, updated on a load |

## Verification
The hardest situation to reach is a chain of codes packed back to back. In that case the second cycle of one code and the first cycle of the next are adjacent, and a decoder that loses its framing would turn a shift into a load. The stimulus drives mixed shift and load codes with no idle cycles between them, including high-high-high-low runs. It places the expected result of each code in a queue at its exact due cycle. The bench also checks one cycle before a load is due, to show that its effect does not appear early. It drives the serial input with a toggling pattern during long idle stretches and then exposes the register with a load, to show that nothing moved.

// File: rtl/dbg_ring_pkg.sv
package dbg_ring_pkg;

  // Strobes from the code decoder to the datapath; at most one is high.
  typedef struct packed {
    logic shiftEn;
    logic loadEn;
  } ringStb_t;

  // Decoder framing: waiting for a first code cycle, or holding one.
  typedef enum logic {
    CTL_WAIT   = 1'b0,
    CTL_SECOND = 1'b1
  } ctlPhase_e;

endpackage

// File: rtl/dbg_ring_pipe.sv
module dbg_ring_pipe #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= '0;
          else     stage[0] <= din;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (rst) stage[g] <= '0;
          else     stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign dout = stage[LAST];

endmodule

// File: rtl/dbg_ring_ctl.sv
module dbg_ring_ctl
  import dbg_ring_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ctlD,
  output ringStb_t stb
);

  ctlPhase_e phase, phaseNext;

  // The decoder acts only in the second cycle of a code.
  always_comb begin
    stb       = '0;
    phaseNext = phase;
    unique case (phase)
      CTL_WAIT: begin
        if (ctlD) phaseNext = CTL_SECOND;
      end
      CTL_SECOND: begin
        stb.shiftEn = ~ctlD;
        stb.loadEn  = ctlD;
        phaseNext   = CTL_WAIT;
      end
      default: phaseNext = CTL_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= CTL_WAIT;
    else     phase <= phaseNext;
  end

endmodule

// File: rtl/dbg_ring_dp.sv
module dbg_ring_dp
  import dbg_ring_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  ringStb_t         stb,
  input  logic             dinD,
  input  logic [WIDTH-1:0] localIn,
  output logic [WIDTH-1:0] shiftReg,
  output logic [WIDTH-1:0] localOut,
  output logic             ringDo
);

  localparam int MSB = WIDTH - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      localOut <= '0;
    end else if (stb.loadEn) begin
      shiftReg <= localIn;
      localOut <= shiftReg;
    end else if (stb.shiftEn) begin
      shiftReg <= {dinD, shiftReg[MSB:1]};
    end
  end

  assign ringDo = shiftReg[0];

endmodule

// File: rtl/dbg_ring_node.sv
module dbg_ring_node
  import dbg_ring_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int CTL_STAGES = 2   // at least 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ringCtl,
  input  logic             ringDi,
  output logic             ringDo,
  input  logic [WIDTH-1:0] localIn,
  output logic [WIDTH-1:0] localOut
);

  localparam int PIPE_W = 2;

  logic [PIPE_W-1:0] pipeIn, pipeOut;
  logic              ctlD, dinD;
  ringStb_t          stb;
  logic [WIDTH-1:0]  shiftReg;

  // Control and serial data share one delay line so they stay aligned.
  assign pipeIn = {ringCtl, ringDi};

  dbg_ring_pipe #(.WIDTH(PIPE_W), .STAGES(CTL_STAGES)) pipe_i (
    .clk(clk), .rst(rst), .din(pipeIn), .dout(pipeOut)
  );

  assign ctlD = pipeOut[1];
  assign dinD = pipeOut[0];

  dbg_ring_ctl ctl_i (
    .clk(clk), .rst(rst), .ctlD(ctlD), .stb(stb)
  );

  dbg_ring_dp #(.WIDTH(WIDTH)) dp_i (
    .clk(clk), .rst(rst), .stb(stb), .dinD(dinD), .localIn(localIn),
    .shiftReg(shiftReg), .localOut(localOut), .ringDo(ringDo)
  );

endmodule

// File: rtl/dbg_ring_node_chk.sv
module dbg_ring_node_chk
  import dbg_ring_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input ringStb_t         stb,
  input logic [WIDTH-1:0] shiftReg,
  input logic [WIDTH-1:0] localIn,
  input logic [WIDTH-1:0] localOut
);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!stb.shiftEn && !stb.loadEn) |=> ($stable(shiftReg) && $stable(localOut))); // R2

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
    stb.shiftEn |=> (shiftReg[WIDTH-2:0] == $past(shiftReg[WIDTH-1:1]) && $stable(localOut))); // R3

  AST_LOAD_SWAP: assert property (@(posedge clk) disable iff (rst)
    stb.loadEn |=> (localOut == $past(shiftReg) && shiftReg == $past(localIn))); // R5

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.shiftEn, stb.loadEn})); // R7

  AST_ACTION_GAP: assert property (@(posedge clk) disable iff (rst)
    (stb.shiftEn || stb.loadEn) |=> !(stb.shiftEn || stb.loadEn)); // R7

endmodule

bind dbg_ring_node dbg_ring_node_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .stb(stb), .shiftReg(shiftReg),
  .localIn(localIn), .localOut(localOut)
);

// File: tb/dbg_ring_node_tb_top.sv
`timescale 1ns/1ps
module dbg_ring_node_tb_top;

  localparam int W = 32;
  localparam int S = 2;

  typedef struct {
    int          due;
    logic        expDo;
    logic [W-1:0] expOut;
    string       req;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ringCtl = 1'b0;
  logic ringDi = 1'b0;
  logic ringDo;
  logic [W-1:0] localIn = '0;
  logic [W-1:0] localOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  expItem_t expQ[$];

  logic [W-1:0] mSr = '0;
  logic [W-1:0] mOut = '0;

  always #2.5 clk = ~clk;   // 200 MHz

  always @(posedge clk) cyc <= cyc + 1;

  dbg_ring_node #(.WIDTH(W), .CTL_STAGES(S)) dut_i (
    .clk(clk), .rst(rst), .ringCtl(ringCtl), .ringDi(ringDi),
    .ringDo(ringDo), .localIn(localIn), .localOut(localOut)
  );

  // Monitor: pop items when due and compare.
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0 && expQ[0].due <= cyc) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (ringDo !== it.expDo) begin
          errors++;
          $display("FAIL %s ringDo got %b exp %b (cycle %0d)", it.req, ringDo, it.expDo, cyc);
        end
        checks++;
        if (localOut !== it.expOut) begin
          errors++;
          $display("FAIL %s localOut got %h exp %h (cycle %0d)", it.req, localOut, it.expOut, cyc);
        end
      end
    end
  end

  task automatic pushExp(int due, string req);
    expItem_t it;
    it.due = due; it.expDo = mSr[0]; it.expOut = mOut; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic idleCycles(int n, bit toggle);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ringCtl = 1'b0;
      ringDi  = toggle ? i[0] : 1'b0;
    end
  endtask

  // One two-cycle code; expected result due CTL_STAGES edges after the second cycle.
  task automatic doCmd(bit isLoad, bit din, string req, bit earlyChk = 1'b0);
    @(negedge clk);
    ringCtl = 1'b1;
    ringDi  = ~din;
    @(negedge clk);
    ringCtl = isLoad;
    ringDi  = din;
    if (earlyChk) pushExp(cyc + S, "R6 early");
    if (isLoad) begin
      mOut = mSr;
      mSr  = localIn;
    end else begin
      mSr = {din, mSr[W-1:1]};
    end
    pushExp(cyc + S + 1, req);
  endtask

  task automatic doReset(string req);
    @(negedge clk);
    rst = 1'b1; ringCtl = 1'b0;
    idleCycles(3, 1'b1);
    @(negedge clk);
    rst = 1'b0;
    mSr = '0; mOut = '0;
    pushExp(cyc + 1, req);
    idleCycles(2, 1'b0);
  endtask

  task automatic drain();
    idleCycles(S + 4, 1'b0);
  endtask

  initial begin
    logic [W-1:0] word;
    fork
      begin
        doReset("R1 reset");
        // Load exposes the zero register and captures localIn.
        localIn = 32'hA5C3_0F96;
        doCmd(1'b1, 1'b0, "R5 load");
        drain();
        // Shift a word in LSB first; old contents leave on ringDo.
        word = 32'h1234_5678;
        for (int b = 0; b < W; b++) doCmd(1'b0, word[b], "R4 shift stream");
        drain();
        localIn = 32'hDEAD_BEEF;
        doCmd(1'b1, 1'b0, "R4 word arrived", 1'b1);
        drain();
        // Idle with toggling serial input: nothing moves.
        pushExp(cyc + 2, "R2 idle");
        idleCycles(14, 1'b1);
        localIn = 32'h0BAD_F00D;
        doCmd(1'b1, 1'b0, "R2 after idle");
        drain();
        // Back-to-back mixed codes.
        localIn = 32'h5555_AAAA;
        doCmd(1'b0, 1'b1, "R3 shift one");
        doCmd(1'b1, 1'b0, "R7 load after shift");
        doCmd(1'b1, 1'b1, "R7 load after load");
        doCmd(1'b0, 1'b1, "R7 shift after load");
        doCmd(1'b0, 1'b0, "R3 shift zero");
        doCmd(1'b1, 1'b0, "R7 load end");
        drain();
        localIn = 32'h8000_0001;
        doCmd(1'b1, 1'b0, "R5 load again", 1'b1);
        doCmd(1'b0, 1'b1, "R3 shift after load");
        drain();
        doReset("R1 reset mid-run");
        doCmd(1'b1, 1'b0, "R1 zero after reset");
        drain();
        if (expQ.size() != 0) begin
          errors++;
          $display("FAIL scoreboard left %0d items exp 0", expQ.size());
        end
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got running exp done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule